// File: doc/BRIEF.md
# Display Line-Fetch Burst Request Generator

This block walks a rectangular frame held in system memory and turns it into read requests on a 128-bit interconnect. Each request carries one beat of 16 bytes, or a burst of 2, 4 or 8 beats. For every line, the start byte address is computed from a plane base address, a first-pixel column, the bytes per pixel, the frame width and an extra row increment. The line is then cut into bursts. Each burst is the largest length allowed by the configured cap, by the alignment of the current beat address and by the beats still left in the line. A burst never reaches into the next line.

A frame can have one plane, or two planes for YUV data. With two planes, the luma lines are fetched first from their own base address. The same number of lines is then fetched from the chroma base address, using the same geometry. A frame starts when `enable` is seen high while the block is idle. After the last request is accepted, `done` pulses for one cycle. The block then waits for `enable` to drop before it can start another frame. The burst-size cap sits in a small register. Writes to it only take effect while the block is disabled and idle.

Width and height are assumed to be at least 1. The other configuration inputs are sampled when a frame starts.

Top module: `linefetch_burst_gen`

## Requirements
- R1: The first request of line y of a plane has address floor((base + x0*bpp + y*(width*bpp + row_inc)) / 16) * 16, where bpp is in bytes.
- R2: Every request address is a multiple of 16, and `req_beats` holds the burst length as a plain count: exactly one of the values 1, 2, 4 or 8.
- R3: A burst of L beats (L > 1) starts on a beat index that is a multiple of L. Each request is the largest of 8, 4, 2 that satisfies the cap, the alignment and the beats left in the line; otherwise it is 1 beat.
- R4: The bursts of a line add up to exactly ceil(width*bpp/16) beats, and consecutive bursts of a line are contiguous.
- R5: The 2-bit burst cap code maps 0 to 2 beats, 1 to 4 beats, and 2 or 3 to 8 beats, and no request exceeds the cap.
- R6: After reset the burst cap is 8 beats.
- R7: A write to the burst cap while `enable` is high or a frame is in progress is ignored.
- R8: When `cfg_two_plane` is 1, the luma lines are followed by `cfg_height` chroma lines computed from `cfg_chroma_base`, with the same x0, bpp, width and row increment.
- R9: While `req_valid` is high and `req_ready` is low, the next cycle keeps `req_valid` high with `req_addr` and `req_beats` unchanged.
- R10: `done` is high for exactly one cycle: the cycle after the last request of the frame is accepted. `req_valid` is low while `done` is high.
- R11: After a frame, no request is issued while `enable` stays high. A new frame starts only after `enable` has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Starts a frame when idle; must drop before the next frame |
| cfg_luma_base | input | ADDR_W | Byte base address of the first (luma) plane |
| cfg_chroma_base | input | ADDR_W | Byte base address of the chroma plane |
| cfg_two_plane | input | 1 | 1 = fetch a second (chroma) plane |
| cfg_x0 | input | PIX_W | Column of the first pixel fetched |
| cfg_bpp | input | BPP_W | Bytes per pixel |
| cfg_width | input | PIX_W | Pixels per line |
| cfg_height | input | LINE_W | Lines per plane |
| cfg_row_inc | input | INC_W | Extra bytes between consecutive lines |
| cfg_burst_wr | input | 1 | Write strobe for the burst cap |
| cfg_burst_code | input | 2 | Burst cap code (0:2, 1:4, 2/3:8 beats) |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted when high with valid |
| req_addr | output | ADDR_W | Byte address of the burst's first beat |
| req_beats | output | 4 | Burst length in beats (1, 2, 4, 8) |
| done | output | 1 | One-cycle pulse after the frame's last acceptance |

## Verification
A wrong beat cursor or remaining-beat count shows up at the very next accepted request. It appears as a shifted address or a wrong length, or as a burst that runs past the line end, which makes the next line's first address wrong. A wrong line counter or plane flag shows up at the first request after a line change, or as a `done` pulse arriving early or late. A cap register that took a locked write, or lost its reset value, changes the length of the first aligned burst of at least 8 beats in the following frame.

// File: rtl/lfb_pkg.sv
// Package: shared state type and burst-cap decoding for the line-fetch
// burst generator. Assumes 16-byte interconnect beats.
package lfb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LINE = 3'd1,
        ST_RUN  = 3'd2,
        ST_DONE = 3'd3,
        ST_HOLD = 3'd4
    } lfb_state_t;

    localparam logic [1:0] CAP_RESET_CODE = 2'd2;

    // Decode the 2-bit cap code into a beat count.
    function automatic logic [3:0] cap_beats(input logic [1:0] code);
        case (code)
            2'd0:    cap_beats = 4'd2;
            2'd1:    cap_beats = 4'd4;
            default: cap_beats = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/lfb_cap_reg.sv
// Module: holds the burst-cap code. Resets to the 8-beat code and accepts
// writes only while unlocked (block disabled and idle).
module lfb_cap_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lock,
    input  logic       wr,
    input  logic [1:0] wdata,
    output logic [1:0] code
);
    import lfb_pkg::*;

    // Update the cap code on an unlocked write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code <= CAP_RESET_CODE;
        else if (wr && !lock)
            code <= wdata;
    end
endmodule

// File: rtl/lfb_line_walker.sv
// Module: tracks plane and line, and produces each line's start byte address
// by adding the row stride. Assumes height >= 1; config sampled on load.
module lfb_line_walker #(
    parameter int ADDR_W = 32,
    parameter int PIX_W  = 12,
    parameter int LINE_W = 12,
    parameter int BPP_W  = 3,
    parameter int INC_W  = 16,
    parameter int LEN_W  = PIX_W + BPP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv_line,
    input  logic [ADDR_W-1:0] luma_base,
    input  logic [ADDR_W-1:0] chroma_base,
    input  logic              two_plane,
    input  logic [PIX_W-1:0]  x0,
    input  logic [BPP_W-1:0]  bpp,
    input  logic [PIX_W-1:0]  width,
    input  logic [LINE_W-1:0] height,
    input  logic [INC_W-1:0]  row_inc,
    output logic [ADDR_W-1:0] line_addr,
    output logic [LEN_W-1:0]  line_beats,
    output logic              last_line
);
    localparam int SUM_W = LEN_W + 1;

    logic [ADDR_W-1:0] x_off, stride, chroma_start;
    logic [LEN_W-1:0]  line_bytes;
    logic [SUM_W-1:0]  rounded;
    logic [LINE_W-1:0] y, last_y;
    logic              plane, two_q;

    // Combinational geometry from the live configuration.
    always_comb begin
        x_off      = ADDR_W'(x0) * ADDR_W'(bpp);
        line_bytes = LEN_W'(width) * LEN_W'(bpp);
        rounded    = SUM_W'(line_bytes) + SUM_W'(15);
    end

    // Plane, line and address bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y <= '0; last_y <= '0; plane <= 1'b0; two_q <= 1'b0;
            line_addr <= '0; stride <= '0; chroma_start <= '0; line_beats <= '0;
        end else if (load) begin
            y            <= '0;
            last_y       <= height - LINE_W'(1);
            plane        <= 1'b0;
            two_q        <= two_plane;
            line_addr    <= luma_base + x_off;
            chroma_start <= chroma_base + x_off;
            stride       <= ADDR_W'(line_bytes) + ADDR_W'(row_inc);
            line_beats   <= LEN_W'(rounded >> 4);
        end else if (adv_line) begin
            if (y == last_y) begin
                y         <= '0;
                plane     <= 1'b1;
                line_addr <= chroma_start;
            end else begin
                y         <= y + LINE_W'(1);
                line_addr <= line_addr + stride;
            end
        end
    end

    // Last line of the last plane.
    always_comb last_line = (y == last_y) && (plane || !two_q);
endmodule

// File: rtl/lfb_burst_sizer.sv
// Module: picks the largest burst (8, 4, 2) allowed by the cap, the beat
// alignment and the beats remaining in the line; falls back to one beat.
module lfb_burst_sizer #(
    parameter int LEN_W = 15
) (
    input  logic [2:0]       beat_lo,
    input  logic [LEN_W-1:0] remain,
    input  logic [3:0]       cap,
    output logic [3:0]       beats
);
    // Priority choice from the longest candidate down.
    always_comb begin
        if (cap >= 4'd8 && remain >= LEN_W'(8) && beat_lo == 3'd0)
            beats = 4'd8;
        else if (cap >= 4'd4 && remain >= LEN_W'(4) && beat_lo[1:0] == 2'd0)
            beats = 4'd4;
        else if (remain >= LEN_W'(2) && !beat_lo[0])
            beats = 4'd2;
        else
            beats = 4'd1;
    end
endmodule

// File: rtl/linefetch_burst_gen.sv
// Module: top of the line-fetch burst generator. Sequences frame, plane and
// line, walks a beat cursor through each line and issues one request per
// handshake. Assumes width >= 1, height >= 1.
module linefetch_burst_gen #(
    parameter int ADDR_W = 32,
    parameter int PIX_W  = 12,
    parameter int LINE_W = 12,
    parameter int BPP_W  = 3,
    parameter int INC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] cfg_luma_base,
    input  logic [ADDR_W-1:0] cfg_chroma_base,
    input  logic              cfg_two_plane,
    input  logic [PIX_W-1:0]  cfg_x0,
    input  logic [BPP_W-1:0]  cfg_bpp,
    input  logic [PIX_W-1:0]  cfg_width,
    input  logic [LINE_W-1:0] cfg_height,
    input  logic [INC_W-1:0]  cfg_row_inc,
    input  logic              cfg_burst_wr,
    input  logic [1:0]        cfg_burst_code,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [3:0]        req_beats,
    output logic              done
);
    import lfb_pkg::*;

    localparam int LEN_W  = PIX_W + BPP_W;
    localparam int BEAT_W = ADDR_W - 4;

    lfb_state_t        state;
    logic [BEAT_W-1:0] cur;
    logic [LEN_W-1:0]  remain, line_beats;
    logic [ADDR_W-1:0] line_addr;
    logic [1:0]        max_code;
    logic [3:0]        beats;
    logic              last_line, load, adv_line, hs, line_end;

    lfb_cap_reg u_cap (
        .clk(clk), .rst_n(rst_n), .lock(enable || state != ST_IDLE),
        .wr(cfg_burst_wr), .wdata(cfg_burst_code), .code(max_code)
    );

    lfb_line_walker #(
        .ADDR_W(ADDR_W), .PIX_W(PIX_W), .LINE_W(LINE_W),
        .BPP_W(BPP_W), .INC_W(INC_W), .LEN_W(LEN_W)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .load(load), .adv_line(adv_line),
        .luma_base(cfg_luma_base), .chroma_base(cfg_chroma_base),
        .two_plane(cfg_two_plane), .x0(cfg_x0), .bpp(cfg_bpp),
        .width(cfg_width), .height(cfg_height), .row_inc(cfg_row_inc),
        .line_addr(line_addr), .line_beats(line_beats), .last_line(last_line)
    );

    lfb_burst_sizer #(.LEN_W(LEN_W)) u_size (
        .beat_lo(cur[2:0]), .remain(remain), .cap(cap_beats(max_code)),
        .beats(beats)
    );

    // Handshake and line-transition strobes.
    always_comb begin
        hs       = (state == ST_RUN) && req_ready;
        line_end = hs && (remain == LEN_W'(beats));
        load     = (state == ST_IDLE) && enable;
        adv_line = line_end && !last_line;
    end

    // Frame sequencer and beat cursor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur    <= '0;
            remain <= '0;
        end else begin
            case (state)
                ST_IDLE: if (enable) state <= ST_LINE;
                ST_LINE: begin
                    cur    <= line_addr[ADDR_W-1:4];
                    remain <= line_beats;
                    state  <= ST_RUN;
                end
                ST_RUN: if (hs) begin
                    if (line_end)
                        state <= last_line ? ST_DONE : ST_LINE;
                    else begin
                        cur    <= cur + BEAT_W'(beats);
                        remain <= remain - LEN_W'(beats);
                    end
                end
                ST_DONE: state <= ST_HOLD;
                ST_HOLD: if (!enable) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request and completion outputs.
    always_comb begin
        req_valid = (state == ST_RUN);
        req_addr  = {cur, 4'b0000};
        req_beats = beats;
        done      = (state == ST_DONE);
    end
endmodule

// File: rtl/lfb_checker.sv
// Module: property checker for linefetch_burst_gen, attached by bind.
module lfb_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [3:0]        req_beats,
    input logic              done,
    input logic [1:0]        max_code
);
    import lfb_pkg::*;

    // R9: stalled request holds.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_beats));

    // R2: beat-aligned address, legal length.
    a_r2_beat_size: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[3:0] == 4'd0 && $countones(req_beats) == 1 && req_beats <= 4'd8);

    // R3: burst aligned to its own size.
    a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[6:4] & 3'(req_beats - 4'd1)) == 3'd0);

    // R5: never exceeds the cap.
    a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_beats <= cap_beats(max_code));

    // R7: cap frozen across enabled cycles.
    a_r7_locked: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(max_code));

    // R10: done is a single pulse with no request alongside.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);
endmodule

bind linefetch_burst_gen lfb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_beats(req_beats),
    .done(done), .max_code(max_code)
);

// File: tb/sim_linefetch_burst_gen.sv
// Bench: sweeps bpp, width, start column, row increment, plane count and cap
// code; expected requests are computed arithmetically per frame.
module sim_linefetch_burst_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] luma_base = '0, chroma_base = '0;
    logic        two_plane = 1'b0;
    logic [11:0] x0 = '0, width = 12'd1, height = 12'd1;
    logic [2:0]  bpp = 3'd1;
    logic [15:0] row_inc = '0;
    logic        burst_wr = 1'b0;
    logic [1:0]  burst_code = '0;
    logic        req_valid, req_ready = 1'b0, done;
    logic [31:0] req_addr;
    logic [3:0]  req_beats;

    int checks = 0, errors = 0;
    int cycles = 0;
    logic [7:0] lfsr = 8'hA5;

    always #5 clk = ~clk;

    linefetch_burst_gen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_luma_base(luma_base), .cfg_chroma_base(chroma_base),
        .cfg_two_plane(two_plane), .cfg_x0(x0), .cfg_bpp(bpp),
        .cfg_width(width), .cfg_height(height), .cfg_row_inc(row_inc),
        .cfg_burst_wr(burst_wr), .cfg_burst_code(burst_code),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_beats(req_beats), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int cap_of(input int code);
        return (code == 0) ? 2 : (code == 1) ? 4 : 8;
    endfunction

    function automatic int pick(input longint cur, input int rem, input int cap);
        if (cap >= 8 && rem >= 8 && cur % 8 == 0) return 8;
        if (cap >= 4 && rem >= 4 && cur % 4 == 0) return 4;
        if (rem >= 2 && cur % 2 == 0) return 2;
        return 1;
    endfunction

    function automatic longint line_beat(input longint base, input int y);
        longint b;
        b = base + longint'(x0) * bpp + longint'(y) * (longint'(width) * bpp + row_inc);
        return (b & 64'hFFFF_FFFF) >> 4;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic set_code(input int c);
        @(negedge clk); burst_wr = 1'b1; burst_code = 2'(c);
        @(negedge clk); burst_wr = 1'b0;
    endtask

    // Runs one frame; poke_code writes cap 0 in mid-frame (must be ignored).
    task automatic run_frame(input int cap, input bit poke_code);
        int plane = 0, y = 0, rem, len, fin_cyc = -10;
        longint cur, base;
        bit finished = 0, got_done = 0, prev_stall = 0, first = 1;
        logic [31:0] p_addr; logic [3:0] p_beats;
        int lbeats = (int'(width) * bpp + 15) / 16;
        cur = line_beat(luma_base, 0); rem = lbeats;
        @(negedge clk); enable = 1'b1;
        for (int cyc = 0; cyc < 4000 && !got_done; cyc++) begin
            @(negedge clk);
            req_ready = lfsr[0] | lfsr[2];
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            burst_wr = poke_code && (cyc == 4);
            burst_code = 2'd0;
            #1;
            if (prev_stall)
                check(req_valid && req_addr == p_addr && req_beats == p_beats,
                      "R9 hold", {req_addr, req_beats}, {p_addr, p_beats});
            if (done) begin
                got_done = 1;
                check(finished && cyc == fin_cyc + 1, "R10 done timing", cyc, fin_cyc + 1);
                check(!req_valid, "R10 valid with done", req_valid, 0);
            end else if (req_valid && req_ready) begin
                if (finished) check(0, "R4 extra request", req_addr, 0);
                else begin
                    len = pick(cur, rem, cap);
                    check(req_addr == 32'(cur << 4),
                          first ? (plane ? "R8 chroma line start" : "R1 line start") : "R4 contiguous",
                          req_addr, cur << 4);
                    check(req_beats == 4'(len), poke_code ? "R7 ignored write" : "R3 R5 burst length",
                          req_beats, len);
                    cur += len; rem -= len; first = 0;
                    if (rem <= 0) begin
                        first = 1;
                        if (y == int'(height) - 1) begin
                            if (plane == 0 && two_plane) begin
                                plane = 1; y = 0;
                            end else begin
                                finished = 1; fin_cyc = cyc;
                            end
                        end else y++;
                        base = plane ? chroma_base : luma_base;
                        cur = line_beat(base, y); rem = lbeats;
                    end
                end
            end
            prev_stall = req_valid && !req_ready;
            p_addr = req_addr; p_beats = req_beats;
        end
        check(got_done, "R10 done seen", got_done, 1);
        req_ready = 1'b1;
        @(negedge clk); #1;
        check(!done, "R10 single pulse", done, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            check(!req_valid, "R11 no restart while enabled", req_valid, 0);
        end
        enable = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!req_valid && !done, "R2 reset outputs idle", {req_valid, done}, 0);
        rst_n = 1'b1;

        // R6: default cap of 8 beats, aligned wide line.
        luma_base = 32'h1000_0000; width = 12'd40; bpp = 3'd4; height = 12'd2;
        run_frame(8, 0);

        // R7: write during an enabled frame is ignored in that frame and after.
        run_frame(8, 1);
        run_frame(8, 0);

        // R5 and R1-style sweep over a small configuration.
        for (int code = 0; code < 4; code++) begin
            set_code(code);
            for (int b = 1; b <= 4; b++)
                for (int wi = 0; wi < 3; wi++)
                    for (int xi = 0; xi < 3; xi++) begin
                        bpp = 3'(b); width = 12'(5 + wi * 9); x0 = 12'(xi * 3);
                        row_inc = 16'(xi * 40); height = 12'(2 + wi % 2);
                        two_plane = 1'((b + xi) % 2);
                        luma_base = 32'h1000_0030 + 32'(code * 16);
                        chroma_base = 32'h2000_0050 + 32'(xi * 16);
                        run_frame(cap_of(code), 0);
                    end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule